// File: doc/BRIEF.md
# Network Activity LED Combiner

This block merges four network activity indications into a single status LED. Each indication has its own enable bit in a small control register. The LED is lit when at least one indication is active and its enable bit is set. The inputs cover transmit activity, any receive activity, collisions, and receive activity that has already passed the node's address filter. The address filter may be in physical, logical-filter, broadcast or promiscuous mode; this block only consumes the result.

The control register sits on a simple synchronous register port: a write strobe with a data word, and a read word that is always valid. The read word returns the four enable bits and a read-only copy of the LED state.

There are three reset-related controls:
- A hard reset puts the enables in their default state.
- A soft reset leaves the enables untouched but blanks the LED.
- A stop control also leaves the enables untouched and also blanks the LED.

The LED output is registered, so it lags the activity inputs by one clock.

Top module: `led_activity_combiner`

## Requirements
- R1: The source and enable bit order is: bit 0 collision, bit 1 any receive, bit 2 address-matched receive, bit 3 transmit. This order applies to `act_i`, `cfg_wdata` and `cfg_rdata[3:0]`.
- R2: When soft reset and stop are low, `led_o` one cycle after a clock edge equals the OR over all sources of (activity AND enable), sampled at that edge.
- R3: Each source lights the LED only through its own enable bit. An active source whose enable bit is clear has no effect on `led_o`.
- R4: Hard reset (`hrst_n` low) sets the enables to 4'b1000, so only transmit is enabled, and clears `led_o`.
- R5: Soft reset (`srst` high) does not change any enable bit.
- R6: Stop (`stop` high) does not change any enable bit.
- R7: Writing `cfg_wdata` with `cfg_we` high loads the enables at that clock edge. The new enables govern the LED value produced at the next edge. Writes are accepted while soft reset or stop is high.
- R8: `cfg_rdata[3:0]` returns the enable bits and `cfg_rdata[4]` returns the current `led_o` value.
- R9: While `srst` or `stop` is high at a clock edge, `led_o` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| hrst_n | input | 1 | Hard reset, active low, asynchronous |
| srst | input | 1 | Soft reset, synchronous, active high |
| stop | input | 1 | Stop control, active high |
| act_i | input | 4 | Activity indications: {tx, rx-match, rx, collision} |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 4 | Enable bits to write |
| cfg_rdata | output | 5 | {LED status, enables} |
| led_o | output | 1 | Combined LED signal |

## Verification
The assertions check on every cycle that:
- the LED tracks the gated OR of the previous cycle's inputs;
- soft reset and stop blank the LED on the next cycle;
- the enables hold without a write;
- a write lands exactly one edge after its strobe.

Only the bench's scenarios can show the hard-reset default of the enables, the bit-to-source mapping seen at the ports, and the status bit seen through the read word. They also show that enables written earlier survive soft reset and stop. Those scenarios read the register back after each such event.

// File: rtl/led_comb_pkg.sv
package led_comb_pkg;

  localparam int unsigned NSRC = 4;

  // Source positions in the activity and enable vectors
  typedef enum logic [1:0] {
    SRC_COL  = 2'd0,
    SRC_RX   = 2'd1,
    SRC_RXM  = 2'd2,
    SRC_TX   = 2'd3
  } src_e;

  localparam logic [NSRC-1:0] EN_HARD_DEFAULT = 4'b1000;

  // Gated OR of activity against enables
  function automatic logic led_combine(input logic [NSRC-1:0] act,
                                       input logic [NSRC-1:0] en);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      hit = hit | (act[i] & en[i]);
    end
    return hit;
  endfunction

endpackage

// File: rtl/led_en_reg.sv
module led_en_reg
  import led_comb_pkg::*;
#(
  parameter int unsigned    W      = NSRC,
  parameter logic [W-1:0]   RST_EN = EN_HARD_DEFAULT
) (
  input  logic         clk,
  input  logic         hrst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en
);

  // Only the hard reset and a write touch the enables
  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n) begin
      en <= RST_EN;
    end else if (we) begin
      en <= wdata;
    end
  end

  // R7: a write lands at the edge after the strobe
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!hrst_n)
    we |=> (en == $past(wdata)));

  // R5 / R6: without a write the enables hold, whatever srst/stop do
  a_r5_r6_en_hold: assert property (@(posedge clk) disable iff (!hrst_n)
    !we |=> $stable(en));

endmodule

// File: rtl/led_gate_or.sv
module led_gate_or
  import led_comb_pkg::*;
#(
  parameter int unsigned W = NSRC
) (
  input  logic         clk,
  input  logic         hrst_n,
  input  logic         srst,
  input  logic         stop,
  input  logic [W-1:0] act,
  input  logic [W-1:0] en,
  output logic         led
);

  logic blank;
  logic [W-1:0] gated;
  logic led_next;

  assign blank = srst | stop;

  // Per-source gating kept as a named vector for inspection
  for (genvar g = 0; g < W; g++) begin : g_gate
    assign gated[g] = act[g] & en[g];
  end

  assign led_next = blank ? 1'b0 : led_combine(act, en);

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n) begin
      led <= 1'b0;
    end else begin
      led <= led_next;
    end
  end

  // R2: registered gated OR of the previous cycle
  a_r2_led_follows: assert property (@(posedge clk) disable iff (!hrst_n)
    !blank |=> (led == $past(|gated)));

  // R9: soft reset or stop blanks the LED on the following cycle
  a_r9_blank: assert property (@(posedge clk) disable iff (!hrst_n)
    blank |=> !led);

  // R3: LED lit only if some source had its enable set
  a_r3_needs_enable: assert property (@(posedge clk) disable iff (!hrst_n)
    ((act & en) == '0) |=> !led);

endmodule

// File: rtl/led_activity_combiner.sv
module led_activity_combiner
  import led_comb_pkg::*;
(
  input  logic            clk,
  input  logic            hrst_n,
  input  logic            srst,
  input  logic            stop,
  input  logic [NSRC-1:0] act_i,
  input  logic            cfg_we,
  input  logic [NSRC-1:0] cfg_wdata,
  output logic [NSRC:0]   cfg_rdata,
  output logic            led_o
);

  logic [NSRC-1:0] en_q;

  led_en_reg #(.W(NSRC), .RST_EN(EN_HARD_DEFAULT)) u_en (
    .clk   (clk),
    .hrst_n(hrst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .en    (en_q)
  );

  led_gate_or #(.W(NSRC)) u_gate (
    .clk   (clk),
    .hrst_n(hrst_n),
    .srst  (srst),
    .stop  (stop),
    .act   (act_i),
    .en    (en_q),
    .led   (led_o)
  );

  // R8: read word carries the status copy above the enables
  assign cfg_rdata = {led_o, en_q};

endmodule

// File: tb/sim_led_activity_combiner.sv
module sim_led_activity_combiner;

  localparam time CLK_P = 10;

  logic       clk = 1'b0;
  logic       hrst_n = 1'b0;
  logic       srst = 1'b0;
  logic       stop = 1'b0;
  logic [3:0] act_i = '0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic [4:0] cfg_rdata;
  logic       led_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  led_activity_combiner u0 (
    .clk(clk), .hrst_n(hrst_n), .srst(srst), .stop(stop), .act_i(act_i),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .led_o(led_o)
  );

  function automatic logic model_led(input logic [3:0] a, input logic [3:0] e);
    return (a[0] && e[0]) || (a[1] && e[1]) || (a[2] && e[2]) || (a[3] && e[3]);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock, inputs driven and checks taken at falling edges
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    hrst_n = 1'b0;
    step();
    chk("R4 enables", cfg_rdata[3:0], 4'b1000);
    chk("R4 led", led_o, 1'b0);
    hrst_n = 1'b1;
    step();
  endtask

  task automatic t_default_tx();
    act_i = 4'b0111; step();
    chk("R3 disabled sources dark", led_o, 1'b0);
    act_i = 4'b1000; step();
    chk("R1 tx bit3 lights", led_o, 1'b1);
    chk("R8 status bit", cfg_rdata[4], 1'b1);
    act_i = 4'b0000; step();
    chk("R2 led drops", led_o, 1'b0);
    chk("R8 status clear", cfg_rdata[4], 1'b0);
  endtask

  task automatic t_each_source();
    for (int s = 0; s < 4; s++) begin
      wr(4'(1 << s));
      chk("R8 readback", cfg_rdata[3:0], 32'(1 << s));
      for (int a = 0; a < 16; a++) begin
        act_i = 4'(a); step();
        chk("R1 R3 single source", led_o, model_led(4'(a), 4'(1 << s)));
      end
    end
    act_i = '0; step();
  endtask

  task automatic t_combos();
    logic [3:0] e;
    for (int k = 0; k < 16; k++) begin
      e = 4'(k * 7 + 3);
      wr(e);
      act_i = 4'(k ^ 5); step();
      chk("R2 combo", led_o, model_led(4'(k ^ 5), e));
    end
    act_i = '0; step();
  endtask

  task automatic t_write_timing();
    wr(4'b0000);
    act_i = 4'b0100;
    // strobe and activity at same edge: old enables (all clear) apply
    cfg_we = 1'b1; cfg_wdata = 4'b0100;
    step();
    cfg_we = 1'b0;
    chk("R7 old enables at strobe edge", led_o, 1'b0);
    step();
    chk("R7 new enables next edge", led_o, 1'b1);
    act_i = '0; step();
  endtask

  task automatic t_soft();
    wr(4'b0110);
    act_i = 4'b0010;
    srst = 1'b1; step();
    chk("R9 soft blanks", led_o, 1'b0);
    chk("R5 enables kept", cfg_rdata[3:0], 4'b0110);
    wr(4'b0011);
    chk("R7 write during soft reset", cfg_rdata[3:0], 4'b0011);
    srst = 1'b0; step();
    chk("R5 led back", led_o, 1'b1);
    act_i = '0; step();
  endtask

  task automatic t_stop();
    wr(4'b1001);
    act_i = 4'b0001;
    stop = 1'b1; step();
    chk("R9 stop blanks", led_o, 1'b0);
    step();
    chk("R6 enables kept", cfg_rdata[3:0], 4'b1001);
    stop = 1'b0; step();
    chk("R6 led back after stop", led_o, 1'b1);
    act_i = '0; step();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_default_tx();
    t_each_source();
    t_combos();
    t_write_timing();
    t_soft();
    t_stop();
    wr(4'b0101);
    t_reset();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule